// File: doc/BRIEF.md
# Dual-Supply Reset Extension Timer

This block is the digital timing core of a reset supervisor. It watches two supply-valid flags, already compared against their thresholds and synchronous to the system clock: one for the main rail and one for a secondary sense input. It also watches an active-low pushbutton input. While any of these reports a problem, the block enables the pull-down on both active-low reset lines.

Once every condition has been good for a programmable number of clock cycles, both pull-downs are released in the same cycle. The default count gives 150 ms at 250 MHz. All fault sources share one retriggerable extension counter. Any fault, including one that arrives partway through an extension, clears the counter, and a full delay is then measured from the point where everything is valid again.

The two pull-down enables come from one internal state bit but leave the block as separate ports. The pad ring can therefore keep the two open-drain lines apart, and an external agent can hold either line low without disturbing the other.

Top module: `supv_reset_timer`

## Requirements
- R1: At any rising clock edge where mainOk or senseOk is 0, both pull-down enables are 1 after that edge.
- R2: rstAPullDn and rstBPullDn carry the same value in every cycle.
- R3: After the last clock edge at which a fault is sampled, the enables fall exactly DELAY_CYCLES edges later, provided no further fault is sampled in between.
- R4: A supply fault sampled while an extension is running discards the partial count, and a full DELAY_CYCLES is measured from the fault's last sampled edge.
- R5: mrN held at 0 keeps both enables at 1. After mrN returns to 1, the enables stay at 1 for DELAY_CYCLES further edges, counted from the first edge at which mrN is 1. This gives a pulse at least as long as the delay.
- R6: An mrN low pulse that starts and ends between two clock edges is captured asynchronously. It counts as a fault at the next edge and starts a full delay.
- R7: During asynchronous reset (rstN = 0) both enables are 1 and the counter is cleared. With all inputs valid, the enables fall DELAY_CYCLES edges after reset is released.
- R8: Once released, both enables stay at 0 for as long as mainOk = 1, senseOk = 1 and mrN = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low logic reset |
| mainOk | input | 1 | Main supply above threshold (1 = valid) |
| senseOk | input | 1 | Secondary sense input above threshold (1 = valid) |
| mrN | input | 1 | Active-low manual reset |
| rstAPullDn | output | 1 | Pull-down enable for reset line A (1 = drive low) |
| rstBPullDn | output | 1 | Pull-down enable for reset line B (1 = drive low) |

## Verification
The hardest situation to reach from the ports is a manual-reset pulse that begins and ends entirely between two clock edges, so that no edge ever samples mrN low. The bench drives a sub-nanosecond pulse in the middle of the low clock phase, and its model treats any low excursion since the previous edge as a fault. A second difficult case is a fault that interrupts an extension partway through. The bench injects a sense fault, waits about half the delay, then drops the main flag, and checks the exact release edge counted from the second fault.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef struct packed {
    logic clear;   // restart extension count
    logic count;   // advance extension count
  } supvStrobes_t;
endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 37_500_000,
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         mrN,
  input  supvStrobes_t strobes,
  output logic         mrSeen,
  output logic         delayDone
);
  logic [CNT_W-1:0] extCnt;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  // Asynchronous capture: any low level on mrN sets the flag at once; the
  // flag survives until an edge at which mrN is high again.
  always_ff @(posedge clk or negedge rstN or negedge mrN) begin
    if (!rstN)     mrSeen <= 1'b0;
    else if (!mrN) mrSeen <= 1'b1;
    else           mrSeen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              extCnt <= '0;
    else if (strobes.clear) extCnt <= '0;
    else if (strobes.count) extCnt <= (extCnt == LAST) ? '0 : extCnt + 1'b1;
  end

  assign delayDone = (extCnt == LAST);
endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         mainOk,
  input  logic         senseOk,
  input  logic         mrSeen,
  input  logic         delayDone,
  output supvStrobes_t strobes,
  output logic         resetActive
);
  logic fault;
  assign fault = !mainOk || !senseOk || mrSeen;

  always_comb begin
    strobes.clear = fault;
    strobes.count = !fault && resetActive;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          resetActive <= 1'b1;
    else if (fault)                     resetActive <= 1'b1;
    else if (resetActive && delayDone)  resetActive <= 1'b0;
  end
endmodule

// File: rtl/supv_reset_timer.sv
module supv_reset_timer
  import supv_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 37_500_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic mainOk,
  input  logic senseOk,
  input  logic mrN,
  output logic rstAPullDn,
  output logic rstBPullDn
);
  supvStrobes_t strobes;
  logic mrSeen, delayDone, resetActive;

  supv_datapath #(.DELAY_CYCLES(DELAY_CYCLES)) uDp (
    .clk(clk), .rstN(rstN), .mrN(mrN), .strobes(strobes),
    .mrSeen(mrSeen), .delayDone(delayDone)
  );

  supv_control uCtl (
    .clk(clk), .rstN(rstN), .mainOk(mainOk), .senseOk(senseOk),
    .mrSeen(mrSeen), .delayDone(delayDone),
    .strobes(strobes), .resetActive(resetActive)
  );

  // Same condition, separate pins: lines are never joined inside.
  assign rstAPullDn = resetActive;
  assign rstBPullDn = resetActive;
endmodule

// File: rtl/supv_reset_timer_chk.sv
module supv_reset_timer_chk #(
  parameter int unsigned DELAY_CYCLES = 37_500_000
) (
  input logic clk,
  input logic rstN,
  input logic mainOk,
  input logic senseOk,
  input logic mrN,
  input logic mrSeen,
  input logic rstAPullDn,
  input logic rstBPullDn
);
  logic [31:0] quietRun;
  logic anyFault;
  assign anyFault = !mainOk || !senseOk || mrSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         quietRun <= '0;
    else if (anyFault) quietRun <= '0;
    else if (quietRun != 32'hFFFF_FFFF) quietRun <= quietRun + 1;
  end

  a_r1_supply_fault_asserts: assert property (@(posedge clk) disable iff (!rstN)
    (!mainOk || !senseOk) |=> (rstAPullDn && rstBPullDn));

  a_r3_no_early_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstAPullDn) |-> (quietRun >= DELAY_CYCLES));

  a_r5_manual_asserts: assert property (@(posedge clk) disable iff (!rstN)
    !mrN |=> (rstAPullDn && rstBPullDn));

  a_r8_stays_released: assert property (@(posedge clk) disable iff (!rstN)
    (!rstAPullDn && mainOk && senseOk && !mrSeen) |=> !rstAPullDn);

  a_r2_lines_track: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstAPullDn) |-> rstBPullDn);
endmodule

bind supv_reset_timer supv_reset_timer_chk #(.DELAY_CYCLES(DELAY_CYCLES)) uChk (
  .clk(clk), .rstN(rstN), .mainOk(mainOk), .senseOk(senseOk), .mrN(mrN),
  .mrSeen(mrSeen), .rstAPullDn(rstAPullDn), .rstBPullDn(rstBPullDn)
);

// File: tb/sim_supv_reset_timer.sv
`timescale 1ns/100ps
module sim_supv_reset_timer;
  localparam int DELAY = 200;

  logic clk = 1'b0, rstN = 1'b0, mainOk = 1'b1, senseOk = 1'b1, mrN = 1'b1;
  logic rstAPullDn, rstBPullDn;

  supv_reset_timer #(.DELAY_CYCLES(DELAY)) u0 (
    .clk(clk), .rstN(rstN), .mainOk(mainOk), .senseOk(senseOk), .mrN(mrN),
    .rstAPullDn(rstAPullDn), .rstBPullDn(rstBPullDn)
  );

  always #2 clk = ~clk;   // 250 MHz

  int compared = 0, mismatched = 0;
  string curReq = "R7";

  // Behavioural reference
  bit modelAsserted = 1;
  int quiet = 0;
  int mrFalls = 0, mrFallsUsed = 0;
  bit mrLowLastEdge = 0;

  always @(negedge mrN) mrFalls++;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelAsserted = 1; quiet = 0; mrLowLastEdge = 0; mrFallsUsed = mrFalls;
    end else begin
      bit fault;
      fault = !mainOk || !senseOk || !mrN || mrLowLastEdge || (mrFalls != mrFallsUsed);
      mrFallsUsed = mrFalls;
      mrLowLastEdge = !mrN;
      if (fault) begin modelAsserted = 1; quiet = 0; end
      else if (modelAsserted) begin
        quiet++;
        if (quiet == DELAY) begin modelAsserted = 0; quiet = 0; end
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rstN) begin
    check(curReq, rstAPullDn, modelAsserted);
    check("R2", rstBPullDn, rstAPullDn);
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mrGlitch();
    @(negedge clk);
    #0.5 mrN = 1'b0;
    #0.3 mrN = 1'b1;
  endtask

  initial begin
    #10;
    check("R7", rstAPullDn, 1'b1);   // reset state
    check("R7", rstBPullDn, 1'b1);
    @(negedge clk); rstN = 1'b1;
    curReq = "R7"; waitCycles(DELAY + 10);
    curReq = "R8"; waitCycles(60);
    curReq = "R1"; @(negedge clk); mainOk = 0; waitCycles(5); mainOk = 1; waitCycles(DELAY + 20);
    @(negedge clk); senseOk = 0; waitCycles(1); senseOk = 1; waitCycles(DELAY + 20);
    curReq = "R3"; @(negedge clk); senseOk = 0; mainOk = 0; waitCycles(3);
    senseOk = 1; mainOk = 1; waitCycles(DELAY + 20);
    curReq = "R4"; @(negedge clk); senseOk = 0; waitCycles(3); senseOk = 1;
    waitCycles(DELAY / 2); mainOk = 0; waitCycles(2); mainOk = 1; waitCycles(DELAY + 20);
    curReq = "R5"; @(negedge clk); mrN = 0; waitCycles(10); mrN = 1; waitCycles(DELAY + 20);
    curReq = "R6"; mrGlitch(); waitCycles(DELAY + 20);
    curReq = "R8"; waitCycles(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule